// File: doc/BRIEF.md
# Double-Precision Special-Case and Exception Resolver

This block sits beside a double-precision add, subtract, multiply and fused multiply-add datapath. It looks at the raw 64-bit operands and sorts each one into zero, infinity, quiet NaN, signaling NaN or an ordinary finite number. When the operands alone settle the answer (a NaN input, an invalid infinity combination, or an infinite result), it produces the final word and the exception flags itself. The datapath's own result is then discarded.

When no operand is special, the block watches the datapath's overflow and underflow indications and the result sign. It picks the saturated or flushed result that the rounding direction calls for. In every other case it reports no bypass, and the datapath result is used. Mantissa arithmetic and normal rounding are not done here.

Each input pulse on `in_valid` is answered by a registered result one clock later. For the two-operand operations, `opnd_a` and `opnd_b` are the operands, and subtract computes a minus b. For the fused operation the result is a + b*c, with `opnd_a` as the accumulator.

Top module: `fp64_special_resolver`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_bypass`, `out_result` and `out_flags` are all zero.
- R2: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. Result, flags and bypass change only in that cycle and hold otherwise.
- R3: A NaN has exponent all ones and a nonzero mantissa; mantissa bit 51 set marks it quiet. A signaling NaN chosen as the result comes out with bit 51 set, with its sign and payload kept, and raises invalid (flag bit 4). Quiet NaN inputs alone raise no flag. Flags are ordered [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow, [0] inexact.
- R4: In add (op 0), sub (op 1) and mul (op 2), the result NaN comes from operand a whenever a is a NaN, otherwise from b. Invalid is raised if either operand is signaling.
- R5: In fused multiply-add (op 3), the result NaN comes from a first, then c, then b. Invalid is raised if any of the three is signaling.
- R6: Adding infinities of opposite effective sign, in add, sub, or the fused sum of an infinite product and an infinite accumulator, returns the default NaN 0x7FF8000000000000 with invalid set.
- R7: A finite operand combined with an infinity returns that infinity with no flags. The sign is negated for the subtrahend of sub, and in a product it is the XOR of the signs.
- R8: Infinity times zero, in mul or in the product of the fused operation, returns the default NaN with invalid set. In the fused operation, when the accumulator is a NaN, the quieted accumulator is returned instead and invalid is still raised.
- R9: With no special operand and overflow reported, the result is an infinity or the largest finite magnitude 0x7FEFFFFFFFFFFFFF with the reported sign, and flags overflow and inexact. Rounding modes are 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf. A positive result gives infinity in modes 0 and 2; a negative result gives infinity in modes 0 and 3.
- R10: With no special operand, no overflow and underflow reported, the result is a signed zero, except that a positive result in mode 2 or a negative result in mode 3 gives the smallest denormal (magnitude 1). Flags are underflow and inexact.
- R11: Operand special cases take priority over datapath overflow and underflow. When nothing applies, bypass is low and result and flags are zero. Divide-by-zero is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle request pulse |
| op | input | 2 | 0 add, 1 sub, 2 mul, 3 fused a + b*c |
| opnd_a | input | 64 | First operand, the accumulator for the fused operation |
| opnd_b | input | 64 | Second operand |
| opnd_c | input | 64 | Third operand, used only by the fused operation |
| rnd_mode | input | 2 | Rounding direction |
| dp_ovf | input | 1 | Datapath overflow indication |
| dp_unf | input | 1 | Datapath underflow indication |
| dp_sign | input | 1 | Sign of the datapath result |
| out_valid | output | 1 | Registered response strobe |
| out_bypass | output | 1 | Result and flags here replace the datapath's |
| out_result | output | 64 | Chosen result word |
| out_flags | output | 5 | Exception flags {invalid, div0, overflow, underflow, inexact} |

## Verification
Two pairs of functions can land in the same request. A NaN or invalid operand combination can arrive while the datapath also reports overflow or underflow. Likewise, an infinity-times-zero product can meet a NaN accumulator. The bench provokes the first pair by asserting the overflow and underflow indications across the exhaustive three-operand sweep, and judges that the operand rule wins whenever one applies. It provokes the second pair with zero and infinity multiplicands against every accumulator value, expecting the quieted accumulator together with the invalid flag.

// File: rtl/fp64_res_pkg.sv
// Shared constants and types for the double-precision special-case resolver.
// Assumes binary64 layout: sign at the top, 11-bit exponent, 52-bit mantissa.
package fp64_res_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int FLAG_W = 5;
    localparam int RM_W   = 2;
    localparam int OP_W   = 2;
    localparam int QBIT   = MAN_W - 1;

    // Flag bit positions
    localparam int FL_INV = 4;
    localparam int FL_DZ  = 3;
    localparam int FL_OVF = 2;
    localparam int FL_UNF = 1;
    localparam int FL_INX = 0;

    localparam logic [FP_W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [FP_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam logic [FP_W-2:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
    localparam logic [FP_W-2:0] TINY_MAG = {{(FP_W-2){1'b0}}, 1'b1};

    typedef enum logic [OP_W-1:0] {
        OPC_ADD = 2'd0,
        OPC_SUB = 2'd1,
        OPC_MUL = 2'd2,
        OPC_FMA = 2'd3
    } opc_e;

    typedef enum logic [RM_W-1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_inf;
        logic is_qnan;
        logic is_snan;
    } fp_class_t;
endpackage

// File: rtl/fp64_classify.sv
// Operand classifier: sorts one binary64 word into zero, infinity, quiet NaN,
// signaling NaN (denormals and normals count as finite nonzero).
// Assumes: purely combinational, no state.
module fp64_classify
    import fp64_res_pkg::*;
(
    input  logic [FP_W-1:0] val,
    output fp_class_t       cls
);
    logic exp_ones;
    logic exp_zero;
    logic man_zero;

    // Decode exponent and mantissa extremes into the class bits
    always_comb begin
        exp_ones    = &val[FP_W-2 -: EXP_W];
        exp_zero    = ~|val[FP_W-2 -: EXP_W];
        man_zero    = ~|val[MAN_W-1:0];
        cls.sign    = val[FP_W-1];
        cls.is_zero = exp_zero & man_zero;
        cls.is_inf  = exp_ones & man_zero;
        cls.is_qnan = exp_ones & val[QBIT];
        cls.is_snan = exp_ones & ~val[QBIT] & ~man_zero;
    end
endmodule

// File: rtl/fp64_nan_pick.sv
// NaN selector: picks the result NaN by fixed operand priority and quiets it.
// Two-operand order is a then b; the fused order is a, then c, then b.
// Assumes: operand c is ignored unless is_fma is high.
module fp64_nan_pick
    import fp64_res_pkg::*;
(
    input  logic            is_fma,
    input  logic [FP_W-1:0] val_a,
    input  logic [FP_W-1:0] val_b,
    input  logic [FP_W-1:0] val_c,
    input  fp_class_t       cls_a,
    input  fp_class_t       cls_b,
    input  fp_class_t       cls_c,
    output logic            nan_any,
    output logic            snan_any,
    output logic [FP_W-1:0] nan_res
);
    localparam int NCAND = 3;

    logic [FP_W-1:0] cand_val [NCAND];
    logic            cand_nan [NCAND];
    logic            cand_sig [NCAND];

    // Arrange candidates in priority order, highest first
    always_comb begin
        cand_val[0] = val_a;
        cand_nan[0] = cls_a.is_qnan | cls_a.is_snan;
        cand_sig[0] = cls_a.is_snan;
        cand_val[1] = is_fma ? val_c : val_b;
        cand_nan[1] = is_fma ? (cls_c.is_qnan | cls_c.is_snan) : (cls_b.is_qnan | cls_b.is_snan);
        cand_sig[1] = is_fma ? cls_c.is_snan : cls_b.is_snan;
        cand_val[2] = val_b;
        cand_nan[2] = is_fma & (cls_b.is_qnan | cls_b.is_snan);
        cand_sig[2] = is_fma & cls_b.is_snan;
    end

    // Scan from lowest to highest priority so the first NaN in order wins
    always_comb begin
        nan_any  = 1'b0;
        snan_any = 1'b0;
        nan_res  = '0;
        for (int i = NCAND - 1; i >= 0; i--) begin
            if (cand_nan[i]) begin
                nan_any = 1'b1;
                nan_res = cand_val[i] | (FP_W'(1) << QBIT);
            end
            snan_any = snan_any | cand_sig[i];
        end
    end
endmodule

// File: rtl/fp64_inf_pick.sv
// Infinity resolver for operands free of NaNs: infinity sums, infinite
// products and infinity-times-zero.
// Assumes: NaN cases are handled upstream and take priority over this.
module fp64_inf_pick
    import fp64_res_pkg::*;
(
    input  opc_e            op,
    input  logic [FP_W-1:0] val_a,
    input  fp_class_t       cls_a,
    input  fp_class_t       cls_b,
    input  fp_class_t       cls_c,
    output logic            hit,
    output logic            invalid,
    output logic            fma_prod_inv,
    output logic [FP_W-1:0] res
);
    logic b_sign_eff;
    logic mul_inv;
    logic mul_inf;
    logic prod_inf;
    logic prod_sign;

    // Product terms for mul (a*b) and for the fused product (b*c)
    always_comb begin
        b_sign_eff   = cls_b.sign ^ (op == OPC_SUB);
        mul_inv      = (cls_a.is_inf & cls_b.is_zero) | (cls_a.is_zero & cls_b.is_inf);
        mul_inf      = cls_a.is_inf | cls_b.is_inf;
        fma_prod_inv = (op == OPC_FMA) &
                       ((cls_b.is_inf & cls_c.is_zero) | (cls_b.is_zero & cls_c.is_inf));
        prod_inf     = cls_b.is_inf | cls_c.is_inf;
        prod_sign    = cls_b.sign ^ cls_c.sign;
    end

    // Choose the special result per operation
    always_comb begin
        hit     = 1'b0;
        invalid = 1'b0;
        res     = '0;
        unique case (op)
            OPC_ADD, OPC_SUB: begin
                if (cls_a.is_inf && cls_b.is_inf && (cls_a.sign != b_sign_eff)) begin
                    hit = 1'b1; invalid = 1'b1; res = DEF_NAN;
                end else if (cls_a.is_inf) begin
                    hit = 1'b1; res = val_a;
                end else if (cls_b.is_inf) begin
                    hit = 1'b1; res = {b_sign_eff, INF_MAG};
                end
            end
            OPC_MUL: begin
                if (mul_inv) begin
                    hit = 1'b1; invalid = 1'b1; res = DEF_NAN;
                end else if (mul_inf) begin
                    hit = 1'b1; res = {cls_a.sign ^ cls_b.sign, INF_MAG};
                end
            end
            default: begin
                if (fma_prod_inv) begin
                    hit = 1'b1; invalid = 1'b1; res = DEF_NAN;
                end else if (prod_inf && cls_a.is_inf && (cls_a.sign != prod_sign)) begin
                    hit = 1'b1; invalid = 1'b1; res = DEF_NAN;
                end else if (prod_inf) begin
                    hit = 1'b1; res = {prod_sign, INF_MAG};
                end else if (cls_a.is_inf) begin
                    hit = 1'b1; res = val_a;
                end
            end
        endcase
    end
endmodule

// File: rtl/fp64_sat_pick.sv
// Saturation selector: turns datapath overflow/underflow into the directed
// result for the rounding mode. Overflow outranks underflow if both are high.
// Assumes: only consulted when no operand special case applies.
module fp64_sat_pick
    import fp64_res_pkg::*;
(
    input  rmode_e            rm,
    input  logic              sign,
    input  logic              ovf,
    input  logic              unf,
    output logic              hit,
    output logic [FP_W-1:0]   res,
    output logic [FLAG_W-1:0] flags
);
    logic away_dir;

    // Rounding toward the sign's own infinity, or nearest on overflow
    always_comb begin
        away_dir = sign ? (rm == RM_DOWN) : (rm == RM_UP);
        hit   = ovf | unf;
        res   = '0;
        flags = '0;
        if (ovf) begin
            res = {sign, (away_dir || rm == RM_NEAR) ? INF_MAG : MAX_MAG};
            flags[FL_OVF] = 1'b1;
            flags[FL_INX] = 1'b1;
        end else if (unf) begin
            res = {sign, away_dir ? TINY_MAG : {(FP_W-1){1'b0}}};
            flags[FL_UNF] = 1'b1;
            flags[FL_INX] = 1'b1;
        end
    end
endmodule

// File: rtl/fp64_special_resolver.sv
// Top of the special-case resolver. Classifies up to three operands, merges
// the NaN, infinity and saturation decisions by priority, and registers the
// outcome one cycle after each in_valid pulse.
// Assumes: in_valid is a single-cycle pulse per request; c used only by fused op.
module fp64_special_resolver
    import fp64_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [FP_W-1:0]   opnd_a,
    input  logic [FP_W-1:0]   opnd_b,
    input  logic [FP_W-1:0]   opnd_c,
    input  logic [RM_W-1:0]   rnd_mode,
    input  logic              dp_ovf,
    input  logic              dp_unf,
    input  logic              dp_sign,
    output logic              out_valid,
    output logic              out_bypass,
    output logic [FP_W-1:0]   out_result,
    output logic [FLAG_W-1:0] out_flags
);
    localparam int NOPND = 3;

    opc_e              opc;
    logic [FP_W-1:0]   opnd [NOPND];
    fp_class_t         cls  [NOPND];

    logic              nan_any, snan_any;
    logic [FP_W-1:0]   nan_res;
    logic              inf_hit, inf_inv, prod_inv;
    logic [FP_W-1:0]   inf_res;
    logic              sat_hit;
    logic [FP_W-1:0]   sat_res;
    logic [FLAG_W-1:0] sat_flags;

    logic              nx_bypass;
    logic [FP_W-1:0]   nx_result;
    logic [FLAG_W-1:0] nx_flags;

    // Gather operands into an indexable array
    always_comb begin
        opc     = opc_e'(op);
        opnd[0] = opnd_a;
        opnd[1] = opnd_b;
        opnd[2] = opnd_c;
    end

    for (genvar g = 0; g < NOPND; g++) begin : g_cls
        fp64_classify u_cls (.val(opnd[g]), .cls(cls[g]));
    end

    fp64_nan_pick u_nan (
        .is_fma  (opc == OPC_FMA),
        .val_a   (opnd[0]),
        .val_b   (opnd[1]),
        .val_c   (opnd[2]),
        .cls_a   (cls[0]),
        .cls_b   (cls[1]),
        .cls_c   (cls[2]),
        .nan_any (nan_any),
        .snan_any(snan_any),
        .nan_res (nan_res)
    );

    fp64_inf_pick u_inf (
        .op          (opc),
        .val_a       (opnd[0]),
        .cls_a       (cls[0]),
        .cls_b       (cls[1]),
        .cls_c       (cls[2]),
        .hit         (inf_hit),
        .invalid     (inf_inv),
        .fma_prod_inv(prod_inv),
        .res         (inf_res)
    );

    fp64_sat_pick u_sat (
        .rm   (rmode_e'(rnd_mode)),
        .sign (dp_sign),
        .ovf  (dp_ovf),
        .unf  (dp_unf),
        .hit  (sat_hit),
        .res  (sat_res),
        .flags(sat_flags)
    );

    // Priority merge: NaN, then infinity rules, then datapath saturation
    always_comb begin
        nx_bypass = 1'b0;
        nx_result = '0;
        nx_flags  = '0;
        if (nan_any) begin
            nx_bypass        = 1'b1;
            nx_result        = nan_res;
            nx_flags[FL_INV] = snan_any | prod_inv;
        end else if (inf_hit) begin
            nx_bypass        = 1'b1;
            nx_result        = inf_res;
            nx_flags[FL_INV] = inf_inv;
        end else if (sat_hit) begin
            nx_bypass = 1'b1;
            nx_result = sat_res;
            nx_flags  = sat_flags;
        end
    end

    // Output register: capture on each request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_bypass <= 1'b0;
            out_result <= '0;
            out_flags  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bypass <= nx_bypass;
                out_result <= nx_result;
                out_flags  <= nx_flags;
            end
        end
    end

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_flags) && !out_valid));
    // R3
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && nan_any) |-> (nan_res[QBIT] && (&nan_res[FP_W-2 -: EXP_W])));
    // R6
    invalid_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[FL_INV]) |-> out_bypass);
    // R9
    ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[FL_OVF]) |->
        (out_result[FP_W-2:0] == INF_MAG || out_result[FP_W-2:0] == MAX_MAG));
    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_bypass) |-> (out_result == '0 && out_flags == '0));
    // R11
    special_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (nan_any || inf_hit)) |=> (out_flags[FL_OVF] == 1'b0 && out_flags[FL_UNF] == 1'b0));
endmodule

// File: tb/fp64_special_resolver_tb.sv
module fp64_special_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [63:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic [1:0]  rnd_mode = '0;
    logic        dp_ovf = 1'b0, dp_unf = 1'b0, dp_sign = 1'b0;
    logic        out_valid, out_bypass;
    logic [63:0] out_result;
    logic [4:0]  out_flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fp64_special_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .rnd_mode(rnd_mode), .dp_ovf(dp_ovf), .dp_unf(dp_unf), .dp_sign(dp_sign),
        .out_valid(out_valid), .out_bypass(out_bypass),
        .out_result(out_result), .out_flags(out_flags)
    );

    localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [62:0] PINF = 63'h7FF0_0000_0000_0000;
    localparam logic [62:0] BIG  = 63'h7FEF_FFFF_FFFF_FFFF;

    logic [63:0] vals [10];
    initial begin
        vals[0] = 64'h0000_0000_0000_0000;
        vals[1] = 64'h8000_0000_0000_0000;
        vals[2] = 64'h3FF0_0000_0000_0000;
        vals[3] = 64'hBFF0_0000_0000_0000;
        vals[4] = 64'h7FF0_0000_0000_0000;
        vals[5] = 64'hFFF0_0000_0000_0000;
        vals[6] = 64'h7FF8_0000_0000_0011;
        vals[7] = 64'h7FF0_0000_0000_0022;
        vals[8] = 64'hFFF8_0000_0000_0033;
        vals[9] = 64'hFFF4_0000_0000_0044;
    end

    function automatic bit f_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction
    function automatic bit f_snan(input logic [63:0] x);
        return f_nan(x) && !x[51];
    endfunction
    function automatic bit f_inf(input logic [63:0] x);
        return x[62:0] == PINF;
    endfunction
    function automatic bit f_zero(input logic [63:0] x);
        return x[62:0] == 63'd0;
    endfunction

    // Reference from the requirements
    task automatic model(input logic [1:0] o, input logic [63:0] a, b, c,
                         input logic [1:0] rm, input logic ov, un, sg,
                         output logic byp, output logic [63:0] r,
                         output logic [4:0] f, output string tag);
        bit fma = (o == 2'd3);
        bit sa, sb;
        int nn;
        byp = 1'b1; r = '0; f = '0; tag = "R11";
        nn = int'(f_nan(a)) + int'(f_nan(b)) + (fma ? int'(f_nan(c)) : 0);
        if (nn > 0) begin
            if (f_nan(a)) r = a;
            else if (fma && f_nan(c)) r = c;
            else r = b;
            r[51] = 1'b1;
            f[4] = f_snan(a) || f_snan(b) || (fma && f_snan(c)) ||
                   (fma && ((f_inf(b) && f_zero(c)) || (f_zero(b) && f_inf(c))));
            tag = (nn == 1) ? "R3" : (fma ? "R5" : "R4");
            if (fma && ((f_inf(b) && f_zero(c)) || (f_zero(b) && f_inf(c)))) tag = "R8";
        end else if (o == 2'd2) begin
            if ((f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b))) begin
                r = DNAN; f[4] = 1'b1; tag = "R8";
            end else if (f_inf(a) || f_inf(b)) begin
                r = {a[63] ^ b[63], PINF}; tag = "R7";
            end else byp = 1'b0;
        end else if (!fma) begin
            sb = b[63] ^ (o == 2'd1);
            if (f_inf(a) && f_inf(b) && a[63] != sb) begin
                r = DNAN; f[4] = 1'b1; tag = "R6";
            end else if (f_inf(a)) begin
                r = a; tag = "R7";
            end else if (f_inf(b)) begin
                r = {sb, PINF}; tag = "R7";
            end else byp = 1'b0;
        end else begin
            sa = b[63] ^ c[63];
            if ((f_inf(b) && f_zero(c)) || (f_zero(b) && f_inf(c))) begin
                r = DNAN; f[4] = 1'b1; tag = "R8";
            end else if ((f_inf(b) || f_inf(c)) && f_inf(a) && a[63] != sa) begin
                r = DNAN; f[4] = 1'b1; tag = "R6";
            end else if (f_inf(b) || f_inf(c)) begin
                r = {sa, PINF}; tag = "R7";
            end else if (f_inf(a)) begin
                r = a; tag = "R7";
            end else byp = 1'b0;
        end
        if (!byp) begin
            if (ov) begin
                byp = 1'b1; f = 5'b00101; tag = "R9";
                if (sg) r = {1'b1, (rm == 2'd0 || rm == 2'd3) ? PINF : BIG};
                else    r = {1'b0, (rm == 2'd0 || rm == 2'd2) ? PINF : BIG};
            end else if (un) begin
                byp = 1'b1; f = 5'b00011; tag = "R10";
                r = {sg, 63'd0};
                if ((sg && rm == 2'd3) || (!sg && rm == 2'd2)) r[0] = 1'b1;
            end
        end
    endtask

    task automatic check(input string tag, input logic byp, input logic [63:0] r, input logic [4:0] f);
        checks++;
        if (out_bypass !== byp || out_result !== r || out_flags !== f || out_valid !== 1'b1) begin
            failures++;
            $display("FAIL %s: got v=%b byp=%b res=%h flg=%b, want v=1 byp=%b res=%h flg=%b",
                     tag, out_valid, out_bypass, out_result, out_flags, byp, r, f);
        end
    endtask

    task automatic run(input logic [1:0] o, input logic [63:0] a, b, c,
                       input logic [1:0] rm, input logic ov, un, sg);
        logic eb; logic [63:0] er; logic [4:0] ef; string tg;
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; opnd_c = c;
        rnd_mode = rm; dp_ovf = ov; dp_unf = un; dp_sign = sg; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(o, a, b, c, rm, ov, un, sg, eb, er, ef, tg);
        check(tg, eb, er, ef);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_bypass !== 0 || out_result !== 0 || out_flags !== 0) begin
            failures++;
            $display("FAIL R1: got v=%b byp=%b res=%h flg=%b, want all zero",
                     out_valid, out_bypass, out_result, out_flags);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Two-operand ops over every pair (R3 R4 R6 R7 R8)
        for (int o = 0; o < 3; o++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run(2'(o), vals[i], vals[j], 64'd0, 2'(j % 4), 1'b0, 1'b0, 1'b0);

        // Fused op over every triple with datapath flags overlapping (R5 R8 R11)
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                for (int k = 0; k < 10; k++)
                    run(2'd3, vals[i], vals[j], vals[k], 2'((i + k) % 4),
                        ((i + j + k) % 3) == 1, ((i + j + k) % 3) == 2, 1'(j % 2));

        // Saturation in every mode and sign (R9 R10), plus none (R11)
        for (int rm = 0; rm < 4; rm++)
            for (int sg = 0; sg < 2; sg++)
                for (int m = 0; m < 4; m++)
                    run(2'(rm), vals[2], vals[3], vals[2], 2'(rm), m[0], m[1], 1'(sg));

        // R2: no request, outputs hold and out_valid drops
        run(2'd2, vals[4], vals[0], 64'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        opnd_a = vals[7]; opnd_b = vals[7]; dp_ovf = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== DNAN || out_flags !== 5'b10000) begin
            failures++;
            $display("FAIL R2: got v=%b res=%h flg=%b, want v=0 res=%h flg=10000",
                     out_valid, out_result, out_flags, DNAN);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog: got timeout, want completion");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule